// File: doc/BRIEF.md
# Cascaded Level Interrupt Controller

This block gathers 24 level-sensitive interrupt request lines and delivers one interrupt to the CPU. The lines form three groups of eight. Each group has its own slave unit, which holds an eight-bit disable mask and eight in-service flags and resolves priority among its lines. The three slaves feed fixed inputs of a master unit with the same structure. Group 0 feeds master input 1, group 1 feeds input 3 and group 2 feeds input 4. The master picks the winning group, and the block raises `cpu_int` while a winner exists.

Software reaches the block through a byte-wide register port at fixed I/O offsets. Each unit has a mask register, which can be read back, and a write-only command register that takes a specific end-of-interrupt. When the CPU pulses `int_ack`, the block latches a vector for the winning global line and marks that line and its master input as in service. Software clears the slave first and then the master before the line, or any line below it, can be served again.

Top module: `casc_irq_ctrl`

## Requirements
- R1: After reset the three group mask registers (offsets 0x537, 0x53B, 0x53D) and the master mask register (offset 0x535) read 0xFF. All in-service flags are clear, `vec_out` is 0x800 and `cpu_int` is low, even with every request line high.
- R2: A write to a mask offset stores the byte, and a read of that offset returns it on `io_rdata` in the same cycle as the address. A read of any other offset, command offsets included, returns 0x00.
- R3: A group mask bit at 1 disables the local line with that bit index. A disabled line never causes `cpu_int`.
- R4: Global line g belongs to group g/8 at local index g mod 8. Groups 0, 1 and 2 drive master inputs 1, 3 and 4. A master mask bit at 1 blocks that input, and a master mask of 0x44 leaves all three cascade inputs enabled.
- R5: Requests are level-sensitive. `cpu_int` follows an eligible line high and low in the same cycle, with no latching of an edge.
- R6: On an `int_ack` pulse while `cpu_int` is high, `vec_out` takes the value 0x800 + 16·g for the winning global line g, starting from the next clock edge.
- R7: Priority is fixed, with the lowest index winning inside a group and the lowest master input winning across groups. Group 0 therefore beats group 1, and group 1 beats group 2.
- R8: An acknowledge sets the in-service flag of the line in its slave and of the input in the master. An in-service flag blocks its own index and every lower-priority index in that unit, while a higher-priority master input can still interrupt.
- R9: A command byte 0xE0 | n written to a slave command offset (0x536, 0x53A, 0x53C) clears local in-service flag n. The byte 0xE0 | k written to the master command offset 0x534 clears master flag k. Command bytes whose upper five bits are not 11100 have no effect.
- R10: An `int_ack` pulse while `cpu_int` is low changes neither `vec_out` nor any in-service flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | 24 | Level request lines, bit g is global line g |
| io_addr | input | 12 | Register port byte offset |
| io_wr | input | 1 | Write strobe for `io_wdata` at `io_addr` |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data for `io_addr`, combinational |
| int_ack | input | 1 | One-cycle interrupt acknowledge from the CPU |
| cpu_int | output | 1 | Interrupt request to the CPU |
| vec_out | output | 12 | Vector of the last acknowledged line |

## Verification
The assertions check on every cycle the properties that hold regardless of the scenario. `cpu_int` never rises without a request line high. The master never marks an input other than a cascade input as in service. A fully masked master never interrupts. `vec_out` moves only on a real acknowledge and always carries a well-formed line vector. The bench's scenarios are needed to show everything that depends on a sequence of events. This covers the exact vector chosen under competing lines, the blocking of a line until both the slave and the master have been cleared, preemption by a higher group, the rejection of malformed command bytes, and an acknowledge that arrives with no request pending.

// File: rtl/cic_pkg.sv
package cic_pkg;

    localparam int GRP_LINES  = 8;
    localparam int NUM_GRPS   = 3;
    localparam int NUM_UNITS  = NUM_GRPS + 1;
    localparam int MASTER_IDX = NUM_GRPS;
    localparam int TOTAL_LINES = GRP_LINES * NUM_GRPS;
    localparam int IDX_W      = $clog2(GRP_LINES);
    localparam int LINE_W     = $clog2(TOTAL_LINES);
    localparam int ADDR_W     = 12;
    localparam int VEC_W      = 12;

    localparam logic [VEC_W-1:0] VEC_BASE = 12'h800;
    localparam logic [4:0]       EOI_TAG  = 5'b11100;

    // unit order: group 0, group 1, group 2, master
    localparam logic [ADDR_W-1:0] MASK_OFS [NUM_UNITS] =
        '{12'h537, 12'h53B, 12'h53D, 12'h535};
    localparam logic [ADDR_W-1:0] CMD_OFS  [NUM_UNITS] =
        '{12'h536, 12'h53A, 12'h53C, 12'h534};

    // master input that each group drives
    localparam logic [IDX_W-1:0] CASC_IN [NUM_GRPS] = '{3'd1, 3'd3, 3'd4};

    typedef struct packed {
        logic             mask_we;
        logic             eoi;
        logic [IDX_W-1:0] eoi_idx;
    } unit_cmd_t;

    typedef struct packed {
        logic [LINE_W-1:0] line;
        logic              valid;
    } ack_sel_t;

    function automatic logic cmd_is_eoi(input logic [7:0] b);
        return b[7:3] == EOI_TAG;
    endfunction

    function automatic logic [VEC_W-1:0] line_vector(input logic [LINE_W-1:0] g);
        return VEC_BASE + VEC_W'({g, 4'h0});
    endfunction

endpackage

// File: rtl/cic_unit.sv
module cic_unit #(
    parameter  int W  = 8,
    localparam int IW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [W-1:0]  req_in,
    input  logic          mask_we,
    input  logic [W-1:0]  mask_wdata,
    input  logic          eoi_valid,
    input  logic [IW-1:0] eoi_idx,
    input  logic          take,
    output logic [W-1:0]  mask_q,
    output logic [W-1:0]  isr_q,
    output logic          req_out,
    output logic [IW-1:0] win_idx
);
    logic [W-1:0]  elig;
    logic [W-1:0]  clr_vec;
    logic [W-1:0]  set_vec;
    logic          blocked;
    logic          found;

    // eligibility: unmasked, not in service, nothing above in service
    always_comb begin
        blocked = 1'b0;
        elig    = '0;
        for (int i = 0; i < W; i++) begin
            elig[i] = req_in[i] & ~mask_q[i] & ~isr_q[i] & ~blocked;
            if (isr_q[i]) blocked = 1'b1;
        end
    end

    // lowest index wins
    always_comb begin
        found   = 1'b0;
        win_idx = '0;
        for (int i = 0; i < W; i++) begin
            if (elig[i] && !found) begin
                win_idx = IW'(i);
                found   = 1'b1;
            end
        end
    end

    assign req_out = found;
    assign clr_vec = eoi_valid ? (W'(1) << eoi_idx) : '0;
    assign set_vec = (take && found) ? (W'(1) << win_idx) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '1;
            isr_q  <= '0;
        end else begin
            if (mask_we) mask_q <= mask_wdata;
            isr_q <= (isr_q & ~clr_vec) | set_vec;
        end
    end
endmodule

// File: rtl/cic_regif.sv
module cic_regif
    import cic_pkg::*;
(
    input  logic [ADDR_W-1:0]                     io_addr,
    input  logic                                  io_wr,
    input  logic [7:0]                            io_wdata,
    input  logic [NUM_UNITS-1:0][GRP_LINES-1:0]   masks,
    output unit_cmd_t [NUM_UNITS-1:0]             cmds,
    output logic [7:0]                            io_rdata
);
    always_comb begin
        io_rdata = 8'h00;
        for (int u = 0; u < NUM_UNITS; u++) begin
            cmds[u].mask_we = io_wr && (io_addr == MASK_OFS[u]);
            cmds[u].eoi     = io_wr && (io_addr == CMD_OFS[u]) && cmd_is_eoi(io_wdata);
            cmds[u].eoi_idx = io_wdata[IDX_W-1:0];
            if (io_addr == MASK_OFS[u]) io_rdata = masks[u];
        end
    end
endmodule

// File: rtl/casc_irq_ctrl.sv
module casc_irq_ctrl
    import cic_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic [TOTAL_LINES-1:0]  irq_lines,
    input  logic [ADDR_W-1:0]       io_addr,
    input  logic                    io_wr,
    input  logic [7:0]              io_wdata,
    output logic [7:0]              io_rdata,
    input  logic                    int_ack,
    output logic                    cpu_int,
    output logic [VEC_W-1:0]        vec_out
);
    unit_cmd_t [NUM_UNITS-1:0]           cmds;
    logic [NUM_UNITS-1:0][GRP_LINES-1:0] masks;
    logic [NUM_GRPS-1:0][GRP_LINES-1:0]  s_isr;
    logic [NUM_GRPS-1:0]                 s_req;
    logic [NUM_GRPS-1:0][IDX_W-1:0]      s_win;
    logic [NUM_GRPS-1:0]                 s_take;
    logic [GRP_LINES-1:0]                m_req;
    logic [GRP_LINES-1:0]                m_isr;
    logic [GRP_LINES-1:0]                m_mask;
    logic [IDX_W-1:0]                    m_win;
    logic                                ack_go;
    ack_sel_t                            sel;

    cic_regif u_regif (
        .io_addr  (io_addr),
        .io_wr    (io_wr),
        .io_wdata (io_wdata),
        .masks    (masks),
        .cmds     (cmds),
        .io_rdata (io_rdata)
    );

    assign ack_go = int_ack && cpu_int;

    for (genvar b = 0; b < NUM_GRPS; b++) begin : g_slave
        assign s_take[b] = ack_go && (m_win == CASC_IN[b]);
        cic_unit #(.W(GRP_LINES)) u_slave (
            .clk        (clk),
            .rst        (rst),
            .req_in     (irq_lines[b*GRP_LINES +: GRP_LINES]),
            .mask_we    (cmds[b].mask_we),
            .mask_wdata (io_wdata),
            .eoi_valid  (cmds[b].eoi),
            .eoi_idx    (cmds[b].eoi_idx),
            .take       (s_take[b]),
            .mask_q     (masks[b]),
            .isr_q      (s_isr[b]),
            .req_out    (s_req[b]),
            .win_idx    (s_win[b])
        );
    end

    // cascade wiring into the master inputs
    always_comb begin
        m_req = '0;
        for (int b = 0; b < NUM_GRPS; b++) m_req[CASC_IN[b]] = s_req[b];
    end

    cic_unit #(.W(GRP_LINES)) u_master (
        .clk        (clk),
        .rst        (rst),
        .req_in     (m_req),
        .mask_we    (cmds[MASTER_IDX].mask_we),
        .mask_wdata (io_wdata),
        .eoi_valid  (cmds[MASTER_IDX].eoi),
        .eoi_idx    (cmds[MASTER_IDX].eoi_idx),
        .take       (ack_go),
        .mask_q     (m_mask),
        .isr_q      (m_isr),
        .req_out    (cpu_int),
        .win_idx    (m_win)
    );

    assign masks[MASTER_IDX] = m_mask;

    // global line of the current winner
    always_comb begin
        sel = '0;
        for (int b = 0; b < NUM_GRPS; b++) begin
            if (m_win == CASC_IN[b]) begin
                sel.line  = LINE_W'(b * GRP_LINES) + LINE_W'(s_win[b]);
                sel.valid = s_req[b];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                    vec_out <= VEC_BASE;
        else if (ack_go && sel.valid) vec_out <= line_vector(sel.line);
    end
endmodule

// File: rtl/cic_checker.sv
module cic_checker
    import cic_pkg::*;
(
    input logic                   clk,
    input logic                   rst,
    input logic [TOTAL_LINES-1:0] irq_lines,
    input logic                   int_ack,
    input logic                   cpu_int,
    input logic [VEC_W-1:0]       vec_out,
    input logic [GRP_LINES-1:0]   m_isr,
    input logic [GRP_LINES-1:0]   m_mask
);
    logic armed;
    logic [GRP_LINES-1:0] casc_bits;

    always_comb begin
        casc_bits = '0;
        for (int b = 0; b < NUM_GRPS; b++) casc_bits[CASC_IN[b]] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    AST_INT_NEEDS_LEVEL: assert property (@(posedge clk) disable iff (rst)
        cpu_int |-> (|irq_lines)); // R5

    AST_VEC_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (armed && !$past(int_ack && cpu_int)) |-> $stable(vec_out)); // R10

    AST_VEC_FORM: assert property (@(posedge clk) disable iff (rst)
        armed |-> (vec_out[3:0] == 4'h0 && vec_out >= VEC_BASE &&
                   vec_out <= line_vector(LINE_W'(TOTAL_LINES - 1)))); // R6

    AST_ACK_MARKS: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(int_ack && cpu_int)) |-> (m_isr != '0)); // R8

    AST_MASTER_CASC_ONLY: assert property (@(posedge clk) disable iff (rst)
        (m_isr & ~casc_bits) == '0); // R4

    AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (rst)
        ((m_mask & casc_bits) == casc_bits) |-> !cpu_int); // R3
endmodule

bind casc_irq_ctrl cic_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .irq_lines (irq_lines),
    .int_ack   (int_ack),
    .cpu_int   (cpu_int),
    .vec_out   (vec_out),
    .m_isr     (m_isr),
    .m_mask    (m_mask)
);

// File: tb/test_casc_irq_ctrl.sv
module test_casc_irq_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [23:0] irq_lines = '0;
    logic [11:0] io_addr = '0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        int_ack = 1'b0;
    logic        cpu_int;
    logic [11:0] vec_out;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    logic [11:0] exp_q[$];
    logic        ack_d = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    casc_irq_ctrl i_casc_irq_ctrl (
        .clk(clk), .rst(rst), .irq_lines(irq_lines), .io_addr(io_addr),
        .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .int_ack(int_ack), .cpu_int(cpu_int), .vec_out(vec_out)
    );

    task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a, input logic [7:0] exp);
        @(negedge clk);
        io_addr = a;
        #1 check(req, {4'h0, io_rdata}, {4'h0, exp});
    endtask

    task automatic set_lines(input logic [23:0] v);
        @(negedge clk);
        irq_lines = v;
    endtask

    task automatic int_chk(input string req, input logic exp);
        #1 check(req, {11'h0, cpu_int}, {11'h0, exp});
    endtask

    // driver: pushes expected vector, pulses acknowledge
    task automatic ack(input logic [11:0] exp_vec);
        @(negedge clk);
        exp_q.push_back(exp_vec);
        int_ack = 1'b1;
        @(negedge clk);
        int_ack = 1'b0;
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // monitor: compares latched vector after each acknowledge
    always @(posedge clk) ack_d <= int_ack;
    always @(negedge clk) begin
        if (ack_d) begin
            if (exp_q.size() == 0) begin
                total++; bad++;
                $display("FAIL R6: actual=%h expected=none", vec_out);
            end else begin
                check("R6 vector", vec_out, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=done");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        rd_chk("R1 mask0", 12'h537, 8'hFF);
        rd_chk("R1 mask1", 12'h53B, 8'hFF);
        rd_chk("R1 mask2", 12'h53D, 8'hFF);
        rd_chk("R1 mmask", 12'h535, 8'hFF);
        check("R1 vec", vec_out, 12'h800);
        set_lines(24'hFFFFFF);
        int_chk("R1 int low", 1'b0);
        set_lines(24'h0);
        // R2 mask storage and read back
        wr(12'h537, 8'h00);
        wr(12'h53B, 8'h5A);
        wr(12'h53D, 8'h00);
        wr(12'h535, 8'h44);
        rd_chk("R2 mask1", 12'h53B, 8'h5A);
        rd_chk("R2 mmask", 12'h535, 8'h44);
        rd_chk("R2 cmd reads 0", 12'h534, 8'h00);
        rd_chk("R2 undecoded", 12'h500, 8'h00);
        wr(12'h53B, 8'h00);
        // R5 level following
        set_lines(24'h000020);
        int_chk("R5 rises", 1'b1);
        set_lines(24'h0);
        int_chk("R5 falls", 1'b0);
        // R6 acknowledge line 5
        set_lines(24'h000020);
        ack(12'h850);
        int_chk("R8 self block", 1'b0);
        set_lines(24'h000200);            // line 9, group 1
        int_chk("R8 lower group blocked", 1'b0);
        wr(12'h536, 8'hE5);
        int_chk("R9 slave eoi only", 1'b0);
        wr(12'h534, 8'hE1);
        int_chk("R9 master eoi", 1'b1);
        ack(12'h890);                      // R4 group 1 line 9
        set_lines(24'h000201);             // line 0 preempts
        int_chk("R8 higher preempts", 1'b1);
        ack(12'h800);
        set_lines(24'h010201);             // line 16 added
        int_chk("R8 group 2 blocked", 1'b0);
        wr(12'h536, 8'hE0);
        wr(12'h534, 8'h61);                // malformed, ignored
        int_chk("R9 bad cmd ignored", 1'b0);
        wr(12'h534, 8'hE1);
        int_chk("R9 master eoi re-enables group 0", 1'b1);
        ack(12'h800);
        set_lines(24'h010000);
        wr(12'h536, 8'hE0);
        wr(12'h534, 8'hE1);
        int_chk("R8 group 1 still blocks", 1'b0);
        wr(12'h53A, 8'hE1);
        wr(12'h534, 8'hE3);
        int_chk("R4 group 2 free", 1'b1);
        ack(12'h900);
        set_lines(24'h0);
        wr(12'h53C, 8'hE0);
        wr(12'h534, 8'hE4);
        // R10 stray acknowledge
        int_chk("R10 idle", 1'b0);
        ack(12'h900);
        set_lines(24'h800000);
        int_chk("R10 no isr left", 1'b1);
        // R7 priority across groups
        set_lines(24'h841000);             // lines 23, 18, 12
        ack(12'h8C0);
        wr(12'h53A, 8'hE4);
        wr(12'h534, 8'hE3);
        set_lines(24'h220000);             // lines 21, 17
        ack(12'h910);
        wr(12'h53C, 8'hE1);
        wr(12'h534, 8'hE4);
        // R3 group mask
        wr(12'h53D, 8'h02);
        set_lines(24'h020000);
        int_chk("R3 masked line", 1'b0);
        wr(12'h53D, 8'h00);
        int_chk("R3 unmasked line", 1'b1);
        // R4 master mask blocks group 2
        wr(12'h535, 8'h54);
        int_chk("R4 master masked", 1'b0);
        wr(12'h535, 8'h44);
        set_lines(24'h800000);
        ack(12'h970);
        repeat (2) @(negedge clk);
        check("R6 queue drained", 12'(exp_q.size()), 12'h0);
        done = 1;
        finish_run();
    end
endmodule